// File: doc/BRIEF.md
# Parallel Control-Register Write Sequencer

This block is the master side of a slow parallel configuration port into a PHY's internal control-register space. It makes the port clock itself by dividing the system clock. It drives a select line, a 16-bit address, a write-enable line and 16-bit write data, and it reads back one acknowledge line. A host pulses a write request with an address and a data word. The block then runs the whole handshake and reports busy, a one-cycle done pulse and a sticky timeout flag.

Every write opens with a fixed burst of port-clock pulses while select is high. Select then drops and the data and write enable are driven. The address goes out on the same system edge that raises the clock and reasserts select. Acknowledge is then sampled once per clock pulse, up to a bounded number of pulses. A write that is never acknowledged only sets the timeout flag, and the block carries on.

A second request runs the port-readiness sequence. It clears the bus, gives one clock pulse with select high, and then polls until acknowledge has dropped. If acknowledge stays high past a limit, the sequence ends with the timeout flag set. All timing is set by parameters counted in system-clock cycles.

Top module: `cfgport_writer`

## Requirements
- R1: While reset is held and directly after it, port_clk, port_sel, port_wen, busy, done and timeout are 0, and port_addr and port_wdata are 0.
- R2: Each high level and each low level of port_clk lasts at least HALF_CYC system-clock cycles. This includes the low time between the end of one request and the first rising clock of the next.
- R3: A write starts with port_sel high and port_wen low, and gives exactly PRE_PULSES (default 15) full port_clk pulses before any data or address is presented.
- R4: After the pre-clock burst, port_sel goes low before port_wen rises, and port_wdata holds the request data when port_wen rises. port_addr changes only on an edge where port_clk goes or stays high with port_sel high. At the first acknowledge-phase rising edge, port_addr and port_wdata equal the request.
- R5: port_ack passes through a two-flop synchroniser and is sampled at the end of each acknowledge-phase high level. The write ends at the first high level in which the synchronised ack is 1. At most ACK_TRIES (default 10) high levels occur in that phase.
- R6: If ack is not seen in ACK_TRIES high levels, timeout is set and done still pulses. The block then returns to idle and accepts the next request.
- R7: A readiness request drives port_addr = 0, port_wdata = 0, port_wen = 0 and port_sel = 1. It gives exactly one port_clk pulse, then checks the synchronised ack every POLL_CYC cycles. It finishes with timeout = 0 at the first check that sees ack low, with port_clk low.
- R8: If ack is still high at a poll check made after READY_LIMIT cycles of polling, the readiness sequence finishes with timeout = 1.
- R9: A request that arrives while busy is 1 has no effect. The running write keeps its address and data, and no further sequence follows it.
- R10: done is high for exactly one cycle per finished sequence. At that point port_clk and port_wen are low. timeout keeps its value until the next accepted request clears it on the accepting edge.
- R11: If a write request and a readiness request arrive in the same idle cycle, the write is the one performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_write | input | 1 | One-cycle write request |
| req_ready | input | 1 | One-cycle readiness-sequence request |
| req_addr | input | 16 | Target register address for a write |
| req_data | input | 16 | Data word for a write |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |
| timeout | output | 1 | Last sequence ran out of attempts or time |
| port_clk | output | 1 | Generated port clock |
| port_sel | output | 1 | Port select |
| port_addr | output | 16 | Port address |
| port_wen | output | 1 | Port write enable |
| port_wdata | output | 16 | Port write data |
| port_ack | input | 1 | Acknowledge from the PHY (asynchronous) |

## Verification
The hardest conditions to reach are at the edge of the retry window. One is an acknowledge that first comes on exactly the last permitted pulse. The other is one that comes one pulse too late, which must end in a timeout. The bench models the PHY so that it raises ack on the K-th rising port clock seen with write enable high. It draws K at random over a range that runs past the attempt limit and also forces K to 1, 10 and 11. A second PHY behaviour holds ack high for a chosen number of cycles, which drives the readiness poll to both the clean exit and the time limit.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE_HI, S_PRE_LO, S_SEL_OFF, S_DATA_SET,
    S_ACK_HI, S_ACK_LO, S_RDY_HI, S_RDY_LO, S_RDY_POLL, S_TAIL
  } seq_state_t;

  // Reload value for a level that must last `cycles` system clocks.
  function automatic int unsigned level_reload(int unsigned cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

  // True when `cnt` (zero-based) is the final slot of a run of `lim`.
  function automatic logic final_slot(int unsigned cnt, int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/cfgport_sync.sv
module cfgport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgport_timer.sv
module cfgport_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cfgport_writer.sv
module cfgport_writer
  import cfgport_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int HALF_CYC    = 250,
  parameter int PRE_PULSES  = 15,
  parameter int ACK_TRIES   = 10,
  parameter int POLL_CYC    = 10000,
  parameter int READY_LIMIT = 5000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_write,
  input  logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          timeout,
  output logic          port_clk,
  output logic          port_sel,
  output logic [AW-1:0] port_addr,
  output logic          port_wen,
  output logic [DW-1:0] port_wdata,
  input  logic          port_ack
);
  localparam int TMAX = (HALF_CYC > POLL_CYC) ? HALF_CYC : POLL_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int PW   = $clog2(PRE_PULSES + 1);
  localparam int KW   = $clog2(ACK_TRIES + 1);
  localparam int LW   = $clog2(READY_LIMIT + 1);
  localparam int HW   = $clog2(HALF_CYC + 1);

  seq_state_t    st;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_data;
  logic [PW-1:0] pre_cnt;
  logic [KW-1:0] try_cnt;
  logic [LW-1:0] elapsed;
  logic          done_q, tmo_q;

  // Named internal events
  logic          ack_s;
  logic          tick;
  logic          accept;
  logic          limit_hit;
  logic          poll_next;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;

  cfgport_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(port_ack), .q(ack_s)
  );

  assign tick      = tmr_exp && (st != S_IDLE);
  assign accept    = (st == S_IDLE) && (req_write || req_ready);
  assign limit_hit = (elapsed >= LW'(READY_LIMIT));
  assign poll_next = (st == S_RDY_LO) || ((st == S_RDY_POLL) && ack_s && !limit_hit);
  assign tmr_load  = accept || tick;
  assign tmr_val   = poll_next ? TW'(level_reload(POLL_CYC)) : TW'(level_reload(HALF_CYC));

  cfgport_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lat_addr   <= '0;
      lat_data   <= '0;
      pre_cnt    <= '0;
      try_cnt    <= '0;
      elapsed    <= '0;
      done_q     <= 1'b0;
      tmo_q      <= 1'b0;
      port_clk   <= 1'b0;
      port_sel   <= 1'b0;
      port_wen   <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (req_write) begin
            lat_addr <= req_addr;
            lat_data <= req_data;
            tmo_q    <= 1'b0;
            pre_cnt  <= '0;
            port_wen <= 1'b0;
            port_sel <= 1'b1;
            port_clk <= 1'b1;
            st       <= S_PRE_HI;
          end else if (req_ready) begin
            tmo_q      <= 1'b0;
            port_addr  <= '0;
            port_wdata <= '0;
            port_wen   <= 1'b0;
            port_sel   <= 1'b1;
            port_clk   <= 1'b1;
            st         <= S_RDY_HI;
          end
        end
        S_PRE_HI: if (tick) begin
          port_clk <= 1'b0;
          st       <= S_PRE_LO;
        end
        S_PRE_LO: if (tick) begin
          if (final_slot(32'(pre_cnt), PRE_PULSES)) begin
            port_sel <= 1'b0;
            st       <= S_SEL_OFF;
          end else begin
            pre_cnt  <= pre_cnt + 1'b1;
            port_clk <= 1'b1;
            st       <= S_PRE_HI;
          end
        end
        S_SEL_OFF: if (tick) begin
          port_wdata <= lat_data;
          port_wen   <= 1'b1;
          st         <= S_DATA_SET;
        end
        S_DATA_SET: if (tick) begin
          port_addr <= lat_addr;
          port_clk  <= 1'b1;
          port_sel  <= 1'b1;
          try_cnt   <= '0;
          st        <= S_ACK_HI;
        end
        S_ACK_HI: if (tick) begin
          if (ack_s) begin
            port_clk <= 1'b0;
            port_wen <= 1'b0;
            st       <= S_TAIL;
          end else if (final_slot(32'(try_cnt), ACK_TRIES)) begin
            tmo_q    <= 1'b1;
            port_clk <= 1'b0;
            port_wen <= 1'b0;
            st       <= S_TAIL;
          end else begin
            try_cnt  <= try_cnt + 1'b1;
            port_clk <= 1'b0;
            st       <= S_ACK_LO;
          end
        end
        S_ACK_LO: if (tick) begin
          port_clk <= 1'b1;
          st       <= S_ACK_HI;
        end
        S_RDY_HI: if (tick) begin
          port_clk <= 1'b0;
          st       <= S_RDY_LO;
        end
        S_RDY_LO: if (tick) begin
          elapsed <= '0;
          st      <= S_RDY_POLL;
        end
        S_RDY_POLL: begin
          if (!limit_hit) elapsed <= elapsed + 1'b1;
          if (tick && !ack_s) begin
            port_clk <= 1'b0;
            st       <= S_TAIL;
          end else if (tick && limit_hit) begin
            tmo_q    <= 1'b1;
            port_clk <= 1'b0;
            st       <= S_TAIL;
          end
        end
        S_TAIL: if (tick) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign timeout = tmo_q;

  // ---------------- assertions ----------------
  logic          clk_d;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d    <= 1'b0;
      hold_cnt <= HW'(HALF_CYC);
    end else begin
      clk_d <= port_clk;
      if (clk_d != port_clk)               hold_cnt <= HW'(1);
      else if (hold_cnt < HW'(HALF_CYC))   hold_cnt <= hold_cnt + 1'b1;
    end
  end

  p_clk_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_clk) |-> hold_cnt >= HW'(HALF_CYC));

  p_addr_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(port_addr) |-> (port_clk && port_sel));

  p_wen_after_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_wen) |-> !port_sel);

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_write) |=> ($stable(lat_addr) && $stable(lat_data)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!port_clk && !port_wen && !busy));

  p_tmo_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (req_write || req_ready)) |=> !timeout);

  p_idle_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!port_clk && !port_sel && !port_wen && !done && !timeout));
endmodule

// File: tb/cfgport_writer_test.sv
module cfgport_writer_test;
  localparam int HALF  = 3;
  localparam int PRE   = 15;
  localparam int TRIES = 10;
  localparam int POLL  = 8;
  localparam int LIMIT = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_write = 1'b0, req_ready = 1'b0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic        busy, done, timeout;
  logic        port_clk, port_sel, port_wen, port_ack;
  logic [15:0] port_addr, port_wdata;

  always #2 clk = ~clk;  // 250 MHz

  cfgport_writer #(
    .HALF_CYC(HALF), .PRE_PULSES(PRE), .ACK_TRIES(TRIES),
    .POLL_CYC(POLL), .READY_LIMIT(LIMIT)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .timeout(timeout), .port_clk(port_clk), .port_sel(port_sel),
    .port_addr(port_addr), .port_wen(port_wen), .port_wdata(port_wdata),
    .port_ack(port_ack)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_phases(input int k);
    return (k <= TRIES) ? k : TRIES;
  endfunction

  function automatic bit exp_fail(input int k);
    return k > TRIES;
  endfunction

  // PHY model and port monitor (sampled on the falling system edge)
  int          k_target = 1;
  logic        wr_ack = 1'b0;
  logic        rdy_ack = 1'b0;
  assign port_ack = wr_ack | rdy_ack;

  logic        prev_clk = 1'b0, prev_wen = 1'b0;
  int          lvl = 1000, lvl_min = 1000;
  int          sel_rises = 0, ack_rises = 0;
  logic [15:0] seen_addr = '0, seen_data = '0, data_at_wen = '0;
  logic        sel_at_wen = 1'b1;

  always @(negedge clk) begin
    if (port_clk != prev_clk) begin
      if (lvl < lvl_min) lvl_min = lvl;
      lvl = 1;
    end else lvl++;
    if (port_wen && !prev_wen) begin
      sel_at_wen  = port_sel;
      data_at_wen = port_wdata;
      ack_rises   = 0;
    end
    if (port_clk && !prev_clk && port_sel && !port_wen) sel_rises++;
    if (port_clk && !prev_clk && port_wen) begin
      ack_rises++;
      if (ack_rises == 1) begin
        seen_addr = port_addr;
        seen_data = port_wdata;
      end
      if (ack_rises == k_target) wr_ack <= 1'b1;
    end
    if (!port_wen && prev_wen) wr_ack <= 1'b0;
    prev_clk = port_clk;
    prev_wen = port_wen;
  end

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int k,
                          input bit poke, input bit both);
    int p0, cyc;
    bit ef;
    ef = exp_fail(k);
    @(negedge clk);
    k_target  = k;
    p0        = sel_rises;
    req_write = 1'b1;
    req_ready = both;
    req_addr  = a;
    req_data  = d;
    @(negedge clk);
    req_write = 1'b0;
    req_ready = 1'b0;
    chk(timeout == 1'b0, "R10 timeout cleared on accept", timeout, 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      req_write = 1'b1; req_ready = 1'b1; req_addr = ~a; req_data = ~d;
      @(negedge clk);
      req_write = 1'b0; req_ready = 1'b0;
    end
    wait_done(cyc);
    chk(timeout == ef, "R6 timeout flag", timeout, ef);
    chk(ack_rises == exp_phases(k), "R5 ack-phase pulses", ack_rises, exp_phases(k));
    chk(sel_rises - p0 == PRE, "R3 pre-clock pulses", sel_rises - p0, PRE);
    chk(seen_addr == a, "R4 address at launch", seen_addr, a);
    chk(seen_data == d && data_at_wen == d, "R4 data at launch", seen_data, d);
    chk(sel_at_wen == 1'b0, "R4 select low when wen rises", sel_at_wen, 0);
    chk(!port_clk && !port_wen, "R10 clock and wen low at done", {port_clk, port_wen}, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    chk(timeout == ef, "R10 timeout holds", timeout, ef);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R9 no sequence after ignored request", busy, 0);
    end
  endtask

  task automatic do_ready(input int hold, input bit exp_to);
    int p0, cyc;
    @(negedge clk);
    rdy_ack   = 1'b1;
    p0        = sel_rises;
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    cyc = 1;
    while (!done) begin
      if (hold >= 0 && cyc >= hold) rdy_ack = 1'b0;
      @(negedge clk);
      cyc++;
    end
    rdy_ack = 1'b0;
    chk(timeout == exp_to, exp_to ? "R8 readiness timeout" : "R7 readiness clean exit",
        timeout, exp_to);
    chk(sel_rises - p0 == 1, "R7 single clock pulse", sel_rises - p0, 1);
    chk(port_addr == 0 && port_wdata == 0 && !port_wen && port_sel,
        "R7 bus cleared", {port_addr, port_wdata}, 0);
    chk(!port_clk, "R7 clock low at end", port_clk, 0);
    if (!exp_to) begin
      chk(cyc >= hold, "R7 exit after ack drop", cyc, hold);
      chk(cyc <= hold + 2 * POLL + 4 * HALF + 6, "R7 poll latency", cyc, hold + 2 * POLL);
    end else begin
      chk(cyc >= LIMIT, "R8 limit respected", cyc, LIMIT);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int k;
    logic [15:0] a, d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(!port_clk && !port_sel && !port_wen && !busy && !done && !timeout &&
        port_addr == 0 && port_wdata == 0, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!port_clk && !port_sel && !busy && !done && !timeout, "R1 after reset", busy, 0);

    do_write(16'h1234, 16'hABCD, 1, 0, 0);
    do_write(16'h00FF, 16'h5A5A, TRIES, 0, 0);        // R5 last permitted attempt
    do_write(16'hFFFF, 16'h0001, TRIES + 1, 0, 0);    // R6 one too late
    do_write(16'h8001, 16'h7FFE, 3, 0, 0);            // R10 timeout cleared by next accept
    do_write(16'h4321, 16'h1111, 4, 1, 0);            // R9 request while busy
    do_write(16'h2468, 16'h1357, 2, 0, 1);            // R11 write wins
    for (int i = 0; i < 16; i++) begin
      a = 16'($urandom);
      d = 16'($urandom);
      k = 1 + int'($urandom % 13);
      do_write(a, d, k, 0, 0);
    end
    do_ready(20, 0);
    do_ready(0, 0);
    do_ready(-1, 1);
    do_write(16'h0F0F, 16'hF0F0, 5, 0, 0);
    chk(lvl_min >= HALF, "R2 minimum clock level", lvl_min, HALF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule